// File: doc/BRIEF.md
# T1 Frame Timing and Sync Generator

This block turns a T1 bit clock into the markers a serial backplane needs. Two counters track where the current bit lies: its position within the 193-bit frame, and the frame number within a multiframe. A multiframe is 12 frames long in D4 format and 24 frames long in ESF format. Every output is decoded from those two counters, so each one tracks the bit that is being clocked in the same cycle.

An external sync pulse sets the alignment. When the pulse is seen, the clock after it carries the framing bit of frame 1. After that the block free-runs, wrapping at the end of each frame and each multiframe. The outputs are:
- a sync pulse that marks either frames or multiframes, with an optional double-width pulse on signaling frames;
- a channel clock that pulses on the last bit of each channel;
- a channel-block signal driven from a 24-bit mask;
- a link clock for the data-link bit stream.

Top module: `t1_frame_timer`

## Requirements
- R1: While reset is asserted and in the first cycle after it, the block is on the framing bit of frame 1. With default controls (frame mode, double-wide off, mask zero), sync_out is 1 and chan_clk, chan_blk and link_clk are 0.
- R2: A frame lasts 193 clocks. Position 0 is the framing bit, and channel c (1..24) occupies positions 8c-7 through 8c. In frame mode with double-wide off, sync_out is high for exactly one clock, at position 0 of every frame.
- R3: The multiframe is 12 frames when esf_mode=0 and 24 frames when esf_mode=1. With mf_sync_mode=1, sync_out is high only at position 0 of frame 1.
- R4: chan_clk is high at positions 8, 16, ..., 192 (the LSB of each channel) and low at all other positions.
- R5: chan_blk equals blk_mask[c-1] for every position inside channel c. blk_mask bit 0 is channel 1. chan_blk is 0 at the framing bit.
- R6: With mf_sync_mode=0 and dbl_wide_en=1, sync_out is also high at position 1 of frames 6, 12, 18 and 24, making a two-clock pulse on those frames.
- R7: With mf_sync_mode=1, dbl_wide_en has no effect on sync_out.
- R8: link_clk depends on zbtsi_en. With zbtsi_en=0 it is high during even-numbered frames (2, 4, ...), giving a period of two frames. With zbtsi_en=1 it is high during frames whose zero-based index has bit 1 set (frames 3, 4, 7, 8, ...), giving a period of four frames.
- R9: sync_in high in a cycle makes the next cycle position 0 of frame 1, from any position.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock, one bit per rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| sync_in | input | 1 | Alignment pulse; the next bit is the framing bit of frame 1 |
| esf_mode | input | 1 | 0: 12-frame multiframe, 1: 24-frame multiframe |
| mf_sync_mode | input | 1 | 0: sync_out marks frames, 1: sync_out marks multiframes |
| dbl_wide_en | input | 1 | Widens the frame-mode sync pulse on signaling frames |
| zbtsi_en | input | 1 | Halves the link clock rate |
| blk_mask | input | 24 | Channel-block level per channel, bit 0 is channel 1 |
| sync_out | output | 1 | Frame or multiframe sync pulse |
| chan_clk | output | 1 | High during the LSB of each channel |
| chan_blk | output | 1 | Masked level of the current channel, 0 on the framing bit |
| link_clk | output | 1 | Link data clock, one or two frames per half period |

## Verification
The bench models bit, channel and frame arithmetically from the number of clocks since the last sync. It compares all four outputs on every clock across whole multiframes in both formats, both sync modes and both link rates. It also re-aligns mid-frame and under several masks.

The corner cases it targets, and how a faulty design would show:
- Frame wrap: a 192- or 194-bit frame shows up as drifting sync pulses.
- Multiframe wrap: a wrong count for D4 or ESF moves the multiframe pulse.
- Mask indexing: an off-by-one in the channel index shifts chan_blk by a bit or a channel, or leaves it high on the framing bit.
- Double-wide gating: a design that ignores the multiframe mode shows a second pulse clock.
- Link rate: a wrong rate inverts the link clock on half the frames.

// File: rtl/t1ft_pkg.sv
`timescale 1ns/1ps
package t1ft_pkg;
  // Channel number (0-based) of a bit position; only meaningful for pos >= 1.
  function automatic int chan_of_pos(input int pos, input int bits_per_ch);
    return (pos - 1) / bits_per_ch;
  endfunction

  // True on the last (least significant) bit of a channel.
  function automatic bit is_chan_lsb(input int pos, input int bits_per_ch);
    return (pos != 0) && ((pos % bits_per_ch) == 0);
  endfunction

  // Signaling frames: every sig_period-th frame, counting from 1.
  function automatic bit is_sig_frame(input int frame_idx, input int sig_period);
    return ((frame_idx + 1) % sig_period) == 0;
  endfunction
endpackage

// File: rtl/t1ft_counter.sv
`timescale 1ns/1ps
module t1ft_counter #(
  parameter int FRAME_BITS = 193,
  parameter int D4_FRAMES  = 12,
  parameter int ESF_FRAMES = 24,
  parameter int BIT_W      = 8,
  parameter int FRM_W      = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sync_in,
  input  logic             esf_mode,
  output logic [BIT_W-1:0] bit_pos,
  output logic [FRM_W-1:0] frame_idx,
  output logic             frame_end
);
  localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(FRAME_BITS - 1);
  localparam logic [FRM_W-1:0] LAST_D4  = FRM_W'(D4_FRAMES - 1);
  localparam logic [FRM_W-1:0] LAST_ESF = FRM_W'(ESF_FRAMES - 1);

  logic [FRM_W-1:0] last_frame;
  assign last_frame = esf_mode ? LAST_ESF : LAST_D4;
  assign frame_end  = (bit_pos == LAST_BIT);

  always_ff @(posedge clk) begin
    if (!rst_n || sync_in) begin
      bit_pos   <= '0;
      frame_idx <= '0;
    end else if (frame_end) begin
      bit_pos   <= '0;
      frame_idx <= (frame_idx >= last_frame) ? '0 : frame_idx + 1'b1;
    end else begin
      bit_pos   <= bit_pos + 1'b1;
    end
  end

  p_bit_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
    bit_pos <= LAST_BIT);
  p_reload_r9: assert property (@(posedge clk) disable iff (!rst_n)
    sync_in |=> (bit_pos == '0 && frame_idx == '0));
  p_mf_wrap_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_end && !sync_in && frame_idx == last_frame) |=> (frame_idx == '0));
  p_frame_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!frame_end && !sync_in) |=> $stable(frame_idx));
endmodule

// File: rtl/t1ft_marker.sv
`timescale 1ns/1ps
module t1ft_marker
  import t1ft_pkg::*;
#(
  parameter int CHANNELS    = 24,
  parameter int BITS_PER_CH = 8,
  parameter int SIG_PERIOD  = 6,
  parameter int BIT_W       = 8,
  parameter int FRM_W       = 5
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                sync_in,
  input  logic [BIT_W-1:0]    bit_pos,
  input  logic [FRM_W-1:0]    frame_idx,
  input  logic                mf_sync_mode,
  input  logic                dbl_wide_en,
  input  logic                zbtsi_en,
  input  logic [CHANNELS-1:0] blk_mask,
  output logic                sync_out,
  output logic                chan_clk,
  output logic                chan_blk,
  output logic                link_clk
);
  int               pos_i;
  int               chan_i;
  logic             in_payload;
  logic             frame_mark;
  logic             mf_mark;
  logic             dbl_mark;
  logic [CHANNELS-1:0] chan_hit;

  always_comb begin
    pos_i      = int'(bit_pos);
    chan_i     = chan_of_pos(pos_i, BITS_PER_CH);
    in_payload = (pos_i != 0);
    frame_mark = (pos_i == 0);
    mf_mark    = frame_mark && (frame_idx == '0);
    dbl_mark   = dbl_wide_en && !mf_sync_mode && (pos_i == 1) &&
                 is_sig_frame(int'(frame_idx), SIG_PERIOD);
  end

  generate
    for (genvar c = 0; c < CHANNELS; c++) begin : g_chan
      assign chan_hit[c] = blk_mask[c] && (chan_i == c);
    end
  endgenerate

  assign chan_clk = is_chan_lsb(pos_i, BITS_PER_CH);
  assign chan_blk = in_payload && (|chan_hit);
  assign sync_out = mf_sync_mode ? mf_mark : (frame_mark || dbl_mark);
  assign link_clk = zbtsi_en ? frame_idx[1] : frame_idx[0];

  p_chclk_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
    chan_clk |=> !chan_clk);
  p_no_double_mf_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (sync_out && mf_sync_mode && $past(mf_sync_mode) && !$past(sync_in)) |-> !$past(sync_out));
  p_link_steady_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (pos_i != 0 && !sync_in && pos_i != CHANNELS*BITS_PER_CH) |=>
      ($stable(link_clk) || !$stable(zbtsi_en)));
  p_blk_fbit_r5: assert property (@(posedge clk) disable iff (!rst_n)
    sync_in |=> !chan_blk);
endmodule

// File: rtl/t1_frame_timer.sv
`timescale 1ns/1ps
module t1_frame_timer #(
  parameter int CHANNELS    = 24,
  parameter int BITS_PER_CH = 8,
  parameter int D4_FRAMES   = 12,
  parameter int ESF_FRAMES  = 24
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                sync_in,
  input  logic                esf_mode,
  input  logic                mf_sync_mode,
  input  logic                dbl_wide_en,
  input  logic                zbtsi_en,
  input  logic [CHANNELS-1:0] blk_mask,
  output logic                sync_out,
  output logic                chan_clk,
  output logic                chan_blk,
  output logic                link_clk
);
  localparam int FRAME_BITS = 1 + CHANNELS * BITS_PER_CH;
  localparam int BIT_W      = $clog2(FRAME_BITS);
  localparam int FRM_W      = $clog2(ESF_FRAMES);
  localparam int SIG_PERIOD = D4_FRAMES / 2;

  logic [BIT_W-1:0] bit_pos;
  logic [FRM_W-1:0] frame_idx;
  logic             frame_end;

  t1ft_counter #(
    .FRAME_BITS(FRAME_BITS), .D4_FRAMES(D4_FRAMES), .ESF_FRAMES(ESF_FRAMES),
    .BIT_W(BIT_W), .FRM_W(FRM_W)
  ) u_cnt (
    .clk(clk), .rst_n(rst_n), .sync_in(sync_in), .esf_mode(esf_mode),
    .bit_pos(bit_pos), .frame_idx(frame_idx), .frame_end(frame_end)
  );

  t1ft_marker #(
    .CHANNELS(CHANNELS), .BITS_PER_CH(BITS_PER_CH), .SIG_PERIOD(SIG_PERIOD),
    .BIT_W(BIT_W), .FRM_W(FRM_W)
  ) u_mark (
    .clk(clk), .rst_n(rst_n), .sync_in(sync_in),
    .bit_pos(bit_pos), .frame_idx(frame_idx),
    .mf_sync_mode(mf_sync_mode), .dbl_wide_en(dbl_wide_en), .zbtsi_en(zbtsi_en),
    .blk_mask(blk_mask),
    .sync_out(sync_out), .chan_clk(chan_clk), .chan_blk(chan_blk), .link_clk(link_clk)
  );

  // A frame pulse in frame mode must land exactly one clock after a frame end.
  p_frame_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_end && !sync_in && !mf_sync_mode && $stable(mf_sync_mode)) |=> sync_out);
endmodule

// File: tb/t1_frame_timer_tb_top.sv
`timescale 1ns/1ps
module t1_frame_timer_tb_top;
  localparam int FB = 193;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sync_in = 1'b0;
  logic        esf_mode = 1'b0;
  logic        mf_sync_mode = 1'b0;
  logic        dbl_wide_en = 1'b0;
  logic        zbtsi_en = 1'b0;
  logic [23:0] blk_mask = '0;
  logic        sync_out, chan_clk, chan_blk, link_clk;

  int checks = 0;
  int fails  = 0;
  int t      = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  t1_frame_timer dut_i (
    .clk(clk), .rst_n(rst_n), .sync_in(sync_in), .esf_mode(esf_mode),
    .mf_sync_mode(mf_sync_mode), .dbl_wide_en(dbl_wide_en), .zbtsi_en(zbtsi_en),
    .blk_mask(blk_mask), .sync_out(sync_out), .chan_clk(chan_clk),
    .chan_blk(chan_blk), .link_clk(link_clk)
  );

  task automatic chk(input string req, input logic act, input logic exp, input int at);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s t=%0d actual=%0b expected=%0b", req, at, act, exp);
    end
  endtask

  // Compare every output against the arithmetic model for the current t.
  task automatic compare_all();
    int  b, f, mf;
    logic e_sync, e_clk, e_blk, e_link;
    mf = esf_mode ? 24 : 12;
    b  = t % FB;
    f  = (t / FB) % mf;
    e_clk = (b >= 8) && ((b & 7) == 0);                 // R4
    e_blk = (b >= 1) && blk_mask[(b - 1) >> 3];          // R5
    if (mf_sync_mode) e_sync = (b == 0) && (f == 0);     // R3, R7
    else e_sync = (b == 0) || (dbl_wide_en && b == 1 && (f % 6) == 5); // R2, R6
    e_link = zbtsi_en ? ((f >> 1) & 1) : (f & 1);        // R8
    chk(mf_sync_mode ? "R3/R7 sync" : "R2/R6 sync", sync_out, e_sync, t);
    chk("R4 chan_clk", chan_clk, e_clk, t);
    chk("R5 chan_blk", chan_blk, e_blk, t);
    chk("R8 link_clk", link_clk, e_link, t);
  endtask

  // One clock: inputs set at negedge, sampled 1 ns later, then the edge.
  task automatic step(input bit do_sync);
    @(negedge clk);
    sync_in = do_sync;
    #1;
    compare_all();
    @(posedge clk);
    t = do_sync ? 0 : t + 1;
  endtask

  task automatic run(input int n);
    for (int i = 0; i < n; i++) step(1'b0);
  endtask

  // Apply new controls together with a sync pulse (R9 realignment).
  task automatic config_and_sync(input bit esf, input bit mfm, input bit dbl,
                                 input bit zb, input logic [23:0] mask);
    @(negedge clk);
    esf_mode = esf; mf_sync_mode = mfm; dbl_wide_en = dbl; zbtsi_en = zb; blk_mask = mask;
    sync_in = 1'b1;
    @(posedge clk);
    t = 0;
    @(negedge clk);
    sync_in = 1'b0;
    #1;
    chk("R9 reload sync", sync_out, 1'b1, 0);
    chk("R9 reload blk", chan_blk, 1'b0, 0);
    @(posedge clk);
    t = 1;
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); #1;
    chk("R1 reset sync", sync_out, 1'b1, 0);
    chk("R1 reset chclk", chan_clk, 1'b0, 0);
    chk("R1 reset blk", chan_blk, 1'b0, 0);
    chk("R1 reset link", link_clk, 1'b0, 0);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk("R1 first bit sync", sync_out, 1'b1, 0);
    @(posedge clk);
    t = 1;
    run(2 * FB);                                          // R2 free run

    config_and_sync(1'b0, 1'b0, 1'b1, 1'b0, 24'hA5_0F_81); // R6 D4 double-wide
    run(2 * 12 * FB);
    config_and_sync(1'b1, 1'b1, 1'b1, 1'b0, 24'hFF_FF_FF); // R3 ESF, R7
    run(2 * 24 * FB);
    config_and_sync(1'b1, 1'b0, 1'b1, 1'b1, 24'h80_00_01); // R6 ESF, R8 ZBTSI
    run(24 * FB + 50);
    config_and_sync(1'b0, 1'b1, 1'b0, 1'b1, 24'h5A_C3_3C); // R3 D4 multiframe
    run(2 * 12 * FB);
    run(777);
    step(1'b1);                                           // R9 mid-frame sync
    run(12 * FB);
    config_and_sync(1'b0, 1'b0, 1'b0, 1'b0, 24'h00_00_00); // R2 plain frames
    run(3 * FB);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule